// File: doc/BRIEF.md
# Keyboard/Mouse Port Register Front End

This block is the software-visible face of one keyboard or mouse serial port. A word-addressed register bus on one side reads and writes a small set of registers. A byte-wide device side on the other side delivers received bytes through a valid/ready handshake and takes transmit bytes as single-cycle strobes. The serial bit engine sits outside this block.

The block keeps one received byte pending until software reads the data register. That read moves the byte into a held register, which keeps the last received value. Receive-parity status is computed from the held byte. Interrupt identification shows the pending flag. A single level interrupt combines the pending flag with an enable bit, and a second control bit can force the interrupt high. A fixed eight-byte identification block occupies the top of the 4 KB window.

Read data is registered. `bus_rdata` carries the word for a read one clock after `bus_rd` is sampled and holds that word until the next read. Only address bits 11..2 are decoded, so the window repeats if `ADDR_W` is wider than 12.

Top module: `kmi_port_regs`

## Requirements
- R1: After reset, control, divisor, held byte and pending flag are all zero. `rx_ready` is 1, `irq` is 0 and `tx_strobe` is 0.
- R2: The control word at byte offset 0x00 and the divisor word at 0x0C store the low CTRL_W and DIV_W bits of a write. Later reads return those bits zero-extended, one cycle after the read strobe.
- R3: The status word at 0x04 reads bit 6 = 1, bit 4 = pending and bit 2 = parity. All other bits read 0.
- R4: The parity bit is the XOR of all 8 bits of the held byte, and not of the pending byte.
- R5: A read of offset 0x08 while a byte is pending returns that byte in bits 7..0, copies it into the held register and clears pending.
- R6: A read of 0x08 with nothing pending returns the held byte unchanged and leaves parity unchanged.
- R7: `irq` = (pending AND control bit 4) OR control bit 3. It follows a control write or a pending change in the next cycle.
- R8: The identification word at 0x10 reads bit 1 = 1 and bit 0 = pending. All other bits read 0.
- R9: A write to 0x08 produces exactly one `tx_strobe` cycle, with `tx_byte` equal to the write data bits 7..0. No other access strobes.
- R10: Reads of 0xFE0, 0xFE4, and so on up to 0xFFC return 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order, in bits 7..0.
- R11: Writes to 0x04, 0x10, the identification block and unmapped offsets change nothing. Reads of unmapped offsets return 0.
- R12: `rx_ready` is 1 exactly while no byte is pending. A byte offered while one is pending is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address (bits 11..2 decoded) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| rx_byte | input | 8 | Received byte from the device side |
| rx_valid | input | 1 | Received byte is offered |
| rx_ready | output | 1 | Block can take a byte |
| tx_byte | output | 8 | Byte to transmit |
| tx_strobe | output | 1 | One-cycle transmit request |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with CTRL_W = 8 and DIV_W = 4. With these widths it can write all 256 control values and all 16 divisor values, and check each against the interrupt formula and the readback. Every byte value 0..255 passes through the receive path, so parity is checked for each possible held byte, including a second back-to-back data read and a byte refused while one is pending. A read sweep over all 1024 word offsets covers the register map, the identification bytes and the unmapped holes.

// File: rtl/kmi_port_regs.sv
module kmi_port_regs #(
  parameter int ADDR_W = 12,
  parameter int CTRL_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic [7:0]        rx_byte,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic [7:0]        tx_byte,
  output logic              tx_strobe,
  output logic              irq
);
  localparam int IDX_W = 10;
  localparam int CTRL_IE = 4;
  localparam int CTRL_FORCE = 3;

  logic [CTRL_W-1:0] ctrl_q;
  logic [DIV_W-1:0]  div_q;
  logic [7:0]        held_q, pend_q;
  logic              pending;
  logic [IDX_W-1:0]  idx;
  logic [31:0]       rd_word;
  logic [7:0]        id_byte;
  logic              sel_ctrl, sel_stat, sel_data, sel_div, sel_iir, sel_id;

  assign idx      = bus_addr[11:2];
  assign sel_ctrl = (idx == 10'd0);
  assign sel_stat = (idx == 10'd1);
  assign sel_data = (idx == 10'd2);
  assign sel_div  = (idx == 10'd3);
  assign sel_iir  = (idx == 10'd4);
  assign sel_id   = &idx[IDX_W-1:3];

  assign rx_ready = !pending;
  assign irq      = (pending && ctrl_q[CTRL_IE]) || ctrl_q[CTRL_FORCE];

  always_comb begin
    case (idx[2:0])
      3'd0: id_byte = 8'h50;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  end

  always_comb begin
    rd_word = '0;
    if (sel_ctrl)      rd_word[CTRL_W-1:0] = ctrl_q;
    else if (sel_stat) rd_word[6:0] = {1'b1, 1'b0, pending, 1'b0, ^held_q, 2'b00};
    else if (sel_data) rd_word[7:0] = pending ? pend_q : held_q;
    else if (sel_div)  rd_word[DIV_W-1:0] = div_q;
    else if (sel_iir)  rd_word[1:0] = {1'b1, pending};
    else if (sel_id)   rd_word[7:0] = id_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      div_q     <= '0;
      held_q    <= '0;
      pend_q    <= '0;
      pending   <= 1'b0;
      bus_rdata <= '0;
      tx_byte   <= '0;
      tx_strobe <= 1'b0;
    end else begin
      tx_strobe <= 1'b0;
      if (rx_valid && !pending) begin
        pending <= 1'b1;
        pend_q  <= rx_byte;
      end
      if (bus_wr) begin
        if (sel_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
        if (sel_div)  div_q  <= bus_wdata[DIV_W-1:0];
        if (sel_data) begin
          tx_strobe <= 1'b1;
          tx_byte   <= bus_wdata[7:0];
        end
      end
      if (bus_rd) begin
        bus_rdata <= rd_word;
        if (sel_data && pending) begin
          held_q  <= pend_q;
          pending <= 1'b0;
        end
      end
    end
  end

  assert_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready |=> !rx_ready);
  assert_consume_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && sel_data && pending |=> rx_ready && bus_rdata[7:0] == $past(pend_q));
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && sel_data && !pending |=> bus_rdata == {24'd0, $past(held_q)});
  assert_tx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && sel_data |=> tx_strobe && tx_byte == $past(bus_wdata[7:0]));
  assert_tx_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && sel_data) |=> !tx_strobe);
  assert_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && sel_ctrl && bus_wdata[CTRL_FORCE] |=> irq);
  assert_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && sel_stat |=> bus_rdata[6] && !bus_rdata[5] && !bus_rdata[3] && bus_rdata[1:0] == 2'b00);
endmodule

// File: tb/kmi_port_regs_tb_top.sv
`timescale 1ns/1ps
module kmi_port_regs_tb_top;
  localparam int CW = 8;
  localparam int DW = 4;

  logic        clk = 0, rst_n = 0;
  logic [11:0] bus_addr = 0;
  logic        bus_wr = 0, bus_rd = 0, rx_valid = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [7:0]  rx_byte = 0, tx_byte;
  logic        rx_ready, tx_strobe, irq;

  int errors = 0, checks = 0, tx_cnt = 0;
  logic [7:0] tx_last = 0;
  logic [7:0] m_held = 0;
  logic [CW-1:0] m_ctrl = 0;
  logic [DW-1:0] m_div = 0;
  logic [7:0] id_tab [8] = '{8'h50, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  kmi_port_regs #(.ADDR_W(12), .CTRL_W(CW), .DIV_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_byte(tx_byte), .tx_strobe(tx_strobe), .irq(irq));

  always #10 clk = ~clk;

  always @(negedge clk) if (rst_n && tx_strobe) begin
    tx_cnt++;
    tx_last = tx_byte;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_byte = b; rx_valid = 1;
    @(negedge clk); rx_valid = 0;
  endtask

  function automatic logic [31:0] model_rd(input int idx);
    if (idx == 0) return 32'(m_ctrl);
    if (idx == 1) return 32'h40 | (32'(^m_held) << 2);
    if (idx == 2) return 32'(m_held);
    if (idx == 3) return 32'(m_div);
    if (idx == 4) return 32'h2;
    if (idx >= 10'h3F8) return 32'(id_tab[idx - 10'h3F8]);
    return 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int t0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(rx_ready == 1 && irq == 0 && tx_strobe == 0, "R1", {rx_ready, irq, tx_strobe}, 3'b100);
    rd(12'h000, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(12'h00C, d); chk(d == 0, "R1 div", d, 0);
    rd(12'h008, d); chk(d == 0, "R1 held", d, 0);
    rd(12'h004, d); chk(d == 32'h40, "R1 status", d, 32'h40);
    rd(12'h010, d); chk(d == 32'h2, "R1 iir", d, 2);

    // R10 identification bytes
    for (int i = 0; i < 8; i++) begin
      rd(12'hFE0 + 12'(4 * i), d); chk(d == 32'(id_tab[i]), "R10", d, 32'(id_tab[i]));
    end

    // R2 divisor sweep
    for (int v = 0; v < (1 << DW); v++) begin
      wr(12'h00C, 32'hABCD_0000 | 32'(v * 17));
      m_div = DW'(v * 17);
      rd(12'h00C, d); chk(d == 32'(m_div), "R2 div", d, 32'(m_div));
    end

    // R7 control sweep with and without pending
    for (int c = 0; c < 256; c++) begin
      wr(12'h000, 32'hFFFF_FF00 | 32'(c));
      m_ctrl = CW'(c);
      chk(irq == m_ctrl[3], "R7 idle", irq, m_ctrl[3]);
      rd(12'h000, d); chk(d == 32'(m_ctrl), "R2 ctrl", d, 32'(m_ctrl));
      send(8'h5A);
      chk(irq == (m_ctrl[3] | m_ctrl[4]), "R7 pending", irq, m_ctrl[3] | m_ctrl[4]);
      rd(12'h008, d); m_held = 8'h5A;
      chk(d == 32'h5A, "R5", d, 32'h5A);
      chk(irq == m_ctrl[3], "R7 consumed", irq, m_ctrl[3]);
    end

    // R4 R5 R6 R8 R12 byte sweep
    wr(12'h000, 32'h10); m_ctrl = 8'h10;
    for (int b = 0; b < 256; b++) begin
      send(8'(b));
      chk(rx_ready == 0, "R12 busy", rx_ready, 0);
      rd(12'h004, d);
      chk(d == (32'h50 | (32'(^m_held) << 2)), "R4 parity uses held", d, 32'h50 | (32'(^m_held) << 2));
      rd(12'h010, d); chk(d == 32'h3, "R8 pending", d, 3);
      chk(irq == 1, "R7 enabled", irq, 1);
      send(~8'(b));
      rd(12'h008, d); m_held = 8'(b);
      chk(d == 32'(b), "R5 R12 first byte kept", d, 32'(b));
      chk(irq == 0 && rx_ready == 1, "R12 free", {irq, rx_ready}, 2'b01);
      rd(12'h004, d);
      chk(d == (32'h40 | (32'(^m_held) << 2)), "R3 R4 status", d, 32'h40 | (32'(^m_held) << 2));
      rd(12'h008, d); chk(d == 32'(b), "R6 repeat", d, 32'(b));
      rd(12'h004, d);
      chk(d[2] == ^m_held, "R6 parity stable", d, 32'h40 | (32'(^m_held) << 2));
      rd(12'h010, d); chk(d == 32'h2, "R8 idle", d, 2);
    end

    // R9 transmit
    for (int i = 0; i < 4; i++) begin
      t0 = tx_cnt;
      wr(12'h008, 32'h1234_5600 | 32'(i * 61));
      @(negedge clk);
      chk(tx_cnt == t0 + 1 && tx_last == 8'(i * 61), "R9", {tx_cnt - t0, tx_last}, {32'd1, 8'(i * 61)});
    end

    // R11 ignored writes
    t0 = tx_cnt;
    wr(12'h004, 32'hFFFF_FFFF); wr(12'h010, 32'hFFFF_FFFF);
    wr(12'h014, 32'hFFFF_FFFF); wr(12'h800, 32'hFFFF_FFFF);
    wr(12'hFE0, 32'hFFFF_FFFF);
    @(negedge clk);
    chk(tx_cnt == t0 && irq == 0, "R11 no side effect", {tx_cnt - t0, irq}, 0);
    rd(12'h000, d); chk(d == 32'(m_ctrl), "R11 ctrl kept", d, 32'(m_ctrl));
    rd(12'h00C, d); chk(d == 32'(m_div), "R11 div kept", d, 32'(m_div));
    rd(12'h008, d); chk(d == 32'(m_held), "R11 held kept", d, 32'(m_held));

    // R11 R10 full read sweep
    for (int i = 0; i < 1024; i++) begin
      rd(12'(i * 4), d);
      chk(d == model_rd(i), "R11 map", d, model_rd(i));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule